// File: doc/BRIEF.md
# Protected-Write Watchdog Timer

This block is a watchdog timer with one control/status register on a simple register bus. Once software enables it, a counter advances on each clock-enable tick. If software does not restart the counter before it reaches the selected terminal count, the block does one of two things. In reset mode it raises a single-cycle system reset request. In interrupt mode it raises a sticky interrupt request.

Software can change the control register only through a two-access sequence. First it makes a control write with the unlock bit set. Then its very next bus access must be the real control write. This protects the register from stray writes.

A status bit records that a timeout happened. The status bit survives the watchdog's own reset but is cleared by the external pin reset, so software can tell the two reset causes apart after boot. A power-monitor event or a lock event forces the watchdog off.

Top module: `wdt_guard`

## Requirements
- R1: After the active-low pin reset `rst_n`, the control register reads 0x00 and both `wd_rst_req` and `wd_irq` are low.
- R2: A control write with bit 2 = 1 arms the unlock and changes no field. If the very next bus access is a control write with bit 2 = 0, that write loads the fields as follows. Bit 0 loads enable. Bit 3 loads mode (1 = interrupt, 0 = reset). Bits 6:4 load the timeout select. Bit 1 = 0 clears status. Bit 7 = 0 clears the pending interrupt. Writing 1 to bit 1 or bit 7 leaves that bit as it is. A control write without a preceding arm changes nothing.
- R3: The arm is used up by the next bus access of any kind: a read, or a write to any address. A control write after such an intervening access has no effect.
- R4: A read at `CTRL_ADDR` returns {irq[7], sel[6:4], mode[3], 0[2], status[1], enable[0]}. Bit 2 always reads 0. Reads at any other address return 0.
- R5: While enabled, a timeout occurs on the 2^(BASE_LOG+sel)-th tick after the counter was last cleared. Cycles with `tick` low do not count.
- R6: Every protected write clears the counter, including a write that sets enable when enable is already 1. This restarts the full timeout period.
- R7: In reset mode, a timeout drives `wd_rst_req` high for exactly one cycle, starting on the clock edge that accepts the final tick.
- R8: In interrupt mode, `wd_irq` rises on the edge that accepts the final tick. It stays high until a protected write with bit 7 = 0, a watchdog reset or a pin reset.
- R9: Status is set by every timeout. It is kept through a watchdog reset. Only `rst_n` or a protected write with bit 1 = 0 clears it.
- R10: A high `wd_rst_in` clears enable, mode, select, the pending interrupt, the unlock arm and the counter, and keeps status.
- R11: A high `psm_evt` or `lock_evt` clears enable (and the counter) on the next edge. This overrides a protected write in the same cycle.
- R12: While enable is 0, ticks cause no timeout, no interrupt and no reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low pin (hardware) reset |
| wd_rst_in | input | 1 | Watchdog-caused system reset, synchronous, active high |
| tick | input | 1 | Counter clock enable |
| acc_valid | input | 1 | Bus access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Register address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data (combinational, valid during a read access) |
| psm_evt | input | 1 | Power-supply-monitor event, forces the watchdog off |
| lock_evt | input | 1 | Lock event, forces the watchdog off |
| wd_rst_req | output | 1 | One-cycle system reset request |
| wd_irq | output | 1 | Sticky watchdog interrupt request |

## Verification
The bench builds the block with BASE_LOG = 2, ADDR_W = 2 and CTRL_ADDR = 1. This brings the terminal counts down to 4 through 512 ticks, so all eight select codes can be swept with an exact tick count against 2^(2+sel). Cycles with the tick held off are included in the sweep.

The bench feeds the reset request back into `wd_rst_in`. This shows status surviving the watchdog's own reset and enable being cleared. A later pin reset then shows status being cleared.

The unlock ordering is driven through its corner cases:
- a control write with no arm;
- a read between the arm and the write;
- a write to the other address between the arm and the write;
- an arm cut off by the watchdog reset;
- a disable event in the same cycle as a protected write.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

  // Control register bit positions (software-visible layout).
  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_STAT  = 1;
  localparam int unsigned B_UNL   = 2;
  localparam int unsigned B_MODE  = 3;
  localparam int unsigned B_SEL   = 4;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned B_IRQ   = 7;

  typedef struct packed {
    logic             irq;
    logic [SEL_W-1:0] sel;
    logic             mode;   // 1 = interrupt, 0 = reset
    logic             status;
    logic             en;
  } wdt_state_t;

  // log2 of the terminal count for a given select
  function automatic int unsigned wdt_term_log(input logic [SEL_W-1:0] sel,
                                               input int unsigned base_log);
    return base_log + int'(sel);
  endfunction

  // register image seen by a read; the unlock bit is never stored
  function automatic logic [7:0] wdt_pack(input wdt_state_t s);
    return {s.irq, s.sel, s.mode, 1'b0, s.status, s.en};
  endfunction

endpackage

// File: rtl/wdt_guard_unlock.sv
module wdt_guard_unlock (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_rst_in,
  input  logic acc_valid,
  input  logic acc_write,
  input  logic is_ctrl,
  input  logic unl_bit,
  output logic arm_req,
  output logic prot_wr,
  output logic armed_q
);

  logic ctrl_wr;

  assign ctrl_wr = acc_valid && acc_write && is_ctrl;
  assign arm_req = ctrl_wr && unl_bit;
  assign prot_wr = ctrl_wr && !unl_bit && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed_q <= 1'b0;
    else if (wd_rst_in) armed_q <= 1'b0;
    else if (acc_valid) armed_q <= arm_req;
  end

  // R3
  arm_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !arm_req) |=> !armed_q);

  // R10
  arm_wdrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_in |=> !armed_q);

endmodule

// File: rtl/wdt_guard_counter.sv
module wdt_guard_counter #(
  parameter int unsigned BASE_LOG = 8,
  localparam int unsigned SEL_W   = wdt_guard_pkg::SEL_W,
  localparam int unsigned CNT_W   = BASE_LOG + (1 << SEL_W) - 1,
  localparam int unsigned TW      = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             timeout
);
  import wdt_guard_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [TW-1:0]    term;

  assign term    = TW'(1) << wdt_term_log(sel, BASE_LOG);
  assign timeout = en && tick && !clr && ({1'b0, cnt_q} == term - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (clr || !en || timeout) cnt_q <= '0;
    else if (tick)                 cnt_q <= cnt_q + CNT_W'(1);
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt_q} < term));

  // R12
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));

  // R6
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_guard_ctrl.sv
module wdt_guard_ctrl
  import wdt_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wd_rst_in,
  input  logic       prot_wr,
  input  wdt_state_t wr_fields,
  input  logic       timeout,
  input  logic       off_evt,
  output wdt_state_t st_q,
  output logic       rst_req_q
);

  logic irq_clr;
  logic stat_clr;

  assign irq_clr  = prot_wr && !wr_fields.irq;
  assign stat_clr = prot_wr && !wr_fields.status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= '0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= timeout && !st_q.mode;
      if (timeout)       st_q.status <= 1'b1;
      else if (stat_clr) st_q.status <= 1'b0;
      if (wd_rst_in) begin
        st_q.en   <= 1'b0;
        st_q.mode <= 1'b0;
        st_q.sel  <= '0;
        st_q.irq  <= 1'b0;
      end else begin
        if (prot_wr) begin
          st_q.en   <= wr_fields.en;
          st_q.mode <= wr_fields.mode;
          st_q.sel  <= wr_fields.sel;
        end
        if (timeout && st_q.mode) st_q.irq <= 1'b1;
        else if (irq_clr)         st_q.irq <= 1'b0;
        if (off_evt) st_q.en <= 1'b0;
      end
    end
  end

  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> !rst_req_q);

  // R9
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> st_q.status);

  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.status && !stat_clr) |=> st_q.status);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.irq && !wd_rst_in && !irq_clr) |=> st_q.irq);

  // R11
  off_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_evt |=> !st_q.en);

  // R10
  wdrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_in |=> (!st_q.en && !st_q.irq && !st_q.mode && st_q.sel == '0));

  // R2
  locked_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_wr && !wd_rst_in) |=> ($stable(st_q.sel) && $stable(st_q.mode)));

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int unsigned BASE_LOG  = 8,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wd_rst_in,
  input  logic              tick,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  output logic [7:0]        acc_rdata,
  input  logic              psm_evt,
  input  logic              lock_evt,
  output logic              wd_rst_req,
  output logic              wd_irq
);

  logic       is_ctrl;
  logic       arm_req;
  logic       prot_wr;
  logic       armed_q;
  logic       off_evt;
  logic       cnt_clr;
  logic       timeout;
  wdt_state_t wr_fields;
  wdt_state_t st_q;

  assign is_ctrl = (acc_addr == ADDR_W'(CTRL_ADDR));
  assign off_evt = psm_evt || lock_evt;
  assign cnt_clr = prot_wr || off_evt || wd_rst_in;

  assign wr_fields.en     = acc_wdata[B_EN];
  assign wr_fields.status = acc_wdata[B_STAT];
  assign wr_fields.mode   = acc_wdata[B_MODE];
  assign wr_fields.sel    = acc_wdata[B_SEL +: SEL_W];
  assign wr_fields.irq    = acc_wdata[B_IRQ];

  wdt_guard_unlock u_unlock (
    .clk       (clk),
    .rst_n     (rst_n),
    .wd_rst_in (wd_rst_in),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .is_ctrl   (is_ctrl),
    .unl_bit   (acc_wdata[B_UNL]),
    .arm_req   (arm_req),
    .prot_wr   (prot_wr),
    .armed_q   (armed_q)
  );

  wdt_guard_counter #(.BASE_LOG(BASE_LOG)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cnt_clr),
    .en      (st_q.en),
    .tick    (tick),
    .sel     (st_q.sel),
    .timeout (timeout)
  );

  wdt_guard_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wd_rst_in (wd_rst_in),
    .prot_wr   (prot_wr),
    .wr_fields (wr_fields),
    .timeout   (timeout),
    .off_evt   (off_evt),
    .st_q      (st_q),
    .rst_req_q (wd_rst_req)
  );

  assign wd_irq    = st_q.irq;
  assign acc_rdata = (acc_valid && !acc_write && is_ctrl) ? wdt_pack(st_q) : 8'h00;

  // R4
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write) |-> (acc_rdata == 8'h00));

  // R12
  no_fire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_q.en |-> !timeout);

  // R2
  prot_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_wr |-> armed_q);

endmodule

// File: tb/sim_wdt_guard.sv
module sim_wdt_guard;
  localparam int unsigned BL = 2;
  localparam int unsigned AW = 2;
  localparam logic [1:0] CA = 2'd1;
  localparam logic [1:0] OA = 2'd2;

  logic clk = 0, rst_n = 0, ext_wdr = 0, tick = 0;
  logic acc_valid = 0, acc_write = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0, acc_rdata;
  logic psm_evt = 0, lock_evt = 0, wd_rst_req, wd_irq, wd_rst_in;
  bit tick_on = 0, tick_half = 0, done = 0;
  int tick_cnt = 0, n_chk = 0, n_fail = 0;
  logic [7:0] rd;

  always #4 clk = ~clk;   // 125 MHz
  assign wd_rst_in = wd_rst_req | ext_wdr;   // watchdog reset loops back

  always @(negedge clk) tick <= tick_on && (!tick_half || !tick);
  always @(posedge clk) if (tick) tick_cnt <= tick_cnt + 1;

  wdt_guard #(.BASE_LOG(BL), .ADDR_W(AW), .CTRL_ADDR(1)) u0 (
    .clk(clk), .rst_n(rst_n), .wd_rst_in(wd_rst_in), .tick(tick),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .psm_evt(psm_evt),
    .lock_evt(lock_evt), .wd_rst_req(wd_rst_req), .wd_irq(wd_irq));

  function automatic logic [7:0] cv(input bit irq, input int sel, input bit mode,
                                    input bit st, input bit en);
    return {irq, 3'(sel), mode, 1'b0, st, en};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; acc_wdata = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_addr = a;
    #1 d = acc_rdata;
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic prot(input logic [7:0] d);
    bus_wr(CA, 8'h04);
    bus_wr(CA, d);
  endtask

  // waits for irq (use_irq) or reset request; returns ticks since call
  task automatic wait_hit(input bit use_irq, output int ticks);
    int base = tick_cnt;
    int guard = 0;
    ticks = -1;
    while (guard < 5000) begin
      @(negedge clk);
      guard++;
      if ((use_irq && wd_irq) || (!use_irq && wd_rst_req)) begin
        ticks = tick_cnt - base;
        break;
      end
    end
  endtask

  task automatic halt_tick();
    tick_on = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 rst_req", wd_rst_req, 0);
    chk("R1 irq", wd_irq, 0);
    bus_rd(CA, rd); chk("R1 ctrl", rd, 8'h00);

    // R2 unprotected write ignored
    bus_wr(CA, 8'h79);
    bus_rd(CA, rd); chk("R2 no arm", rd, 8'h00);
    // R3 arm used up by a read, then by a write elsewhere
    bus_wr(CA, 8'h04); bus_rd(OA, rd); bus_wr(CA, 8'h79);
    bus_rd(CA, rd); chk("R3 read between", rd, 8'h00);
    bus_wr(CA, 8'h04); bus_wr(OA, 8'h00); bus_wr(CA, 8'h79);
    bus_rd(CA, rd); chk("R3 write between", rd, 8'h00);

    // R2 R4 protected write and readback
    prot(8'h29);
    bus_rd(CA, rd); chk("R2 R4 ctrl", rd, cv(0, 2, 1, 0, 1));
    bus_rd(OA, rd); chk("R4 other addr", rd, 8'h00);

    // R5 R8 R9 sweep all selects, interrupt mode
    for (int s = 0; s < 8; s++) begin
      halt_tick();
      prot(cv(0, s, 1, 1, 1));
      tick_on = 1;
      wait_hit(1, t);
      halt_tick();
      chk($sformatf("R5 R8 sel%0d ticks", s), t, 1 << (BL + s));
      bus_rd(CA, rd); chk($sformatf("R9 sel%0d status", s), rd, cv(1, s, 1, 1, 1));
      prot(cv(1, s, 1, 1, 1));
      bus_rd(CA, rd); chk("R8 irq held by bit7=1", rd, cv(1, s, 1, 1, 1));
      prot(cv(0, s, 1, 1, 1));
      bus_rd(CA, rd); chk("R8 irq cleared", rd, cv(0, s, 1, 1, 1));
    end

    // R5 half-rate ticks
    prot(cv(0, 2, 1, 1, 1));
    tick_half = 1; tick_on = 1;
    wait_hit(1, t);
    halt_tick(); tick_half = 0;
    chk("R5 gated ticks", t, 1 << (BL + 2));

    // R6 restart mid-period
    prot(cv(0, 3, 1, 1, 1));
    tick_on = 1;
    repeat (20) @(negedge clk);
    halt_tick();
    chk("R6 no early irq", wd_irq, 0);
    prot(cv(0, 3, 1, 1, 1));
    tick_on = 1;
    wait_hit(1, t);
    halt_tick();
    chk("R6 full period after restart", t, 1 << (BL + 3));

    // R9 status cleared by protected write
    prot(8'h00);
    bus_rd(CA, rd); chk("R9 status cleared", rd, 8'h00);

    // R7 R9 R10 reset mode with loopback
    prot(cv(0, 1, 0, 0, 1));
    tick_on = 1;
    wait_hit(0, t);
    tick_on = 0;
    chk("R7 ticks", t, 1 << (BL + 1));
    @(negedge clk);
    chk("R7 one cycle", wd_rst_req, 0);
    halt_tick();
    bus_rd(CA, rd); chk("R9 R10 status kept, en off", rd, 8'h02);

    // R10 external watchdog reset, also cancels an arm
    prot(cv(0, 7, 1, 1, 1));
    bus_wr(CA, 8'h04);
    @(negedge clk); ext_wdr = 1; @(negedge clk); ext_wdr = 0;
    bus_wr(CA, 8'h51);
    bus_rd(CA, rd); chk("R10 fields cleared, arm gone", rd, 8'h02);

    // R9 pin reset clears status
    @(negedge clk); rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
    bus_rd(CA, rd); chk("R9 pin reset", rd, 8'h00);

    // R11 events force off, including over a same-cycle protected write
    prot(8'h01);
    @(negedge clk); psm_evt = 1; @(negedge clk); psm_evt = 0;
    bus_rd(CA, rd); chk("R11 psm", rd, 8'h00);
    bus_wr(CA, 8'h04);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_addr = CA; acc_wdata = 8'h21; lock_evt = 1;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; lock_evt = 0;
    bus_rd(CA, rd); chk("R11 lock beats write", rd, 8'h20);

    // R12 disabled watchdog ignores ticks
    tick_on = 1;
    begin
      bit seen = 0;
      for (int i = 0; i < 600; i++) begin
        @(negedge clk);
        if (wd_irq || wd_rst_req) seen = 1;
      end
      chk("R12 no event while off", seen, 0);
    end
    halt_tick();
    bus_rd(CA, rd); chk("R12 status untouched", rd, 8'h20);

    report();
  end
endmodule